// File: doc/BRIEF.md
# Serial Configuration Port

This block is the write-only control port of a multi-motor driver. A host shifts 16-bit words over three wires (a shift clock, a data line and a strobe). Each strobe rising edge commits the last word to one of three register banks. Which bank receives the word depends on two things: the `awake` input, and the level of the data line at the moment of the strobe edge. The banks are the setup bank (motor configuration, blanking selects, regulator off bits), the extended bank (monitor signal select), and the stepper parameter bank. Every bank is presented as parallel outputs.

The serial inputs are sampled by the system clock and are assumed to already be synchronous to it. A strobe is accepted only when exactly one word's worth of shift-clock falls has arrived since the previous strobe. Strobes are also ignored for a programmable window after `awake` changes level. A registered monitor pin shows either one of the external status signals, a bit of a fixed device or vendor identifier, or a constant high that models a released open-drain pin.

Top module: `serial_cfg_port`

## Requirements
- R1: On every falling edge of `sclk`, the bit on `sdata` enters the shift register at bit 0 and the older bits move up one place. The first bit sent therefore ends in bit 15 of the committed word.
- R2: With `awake` low, a strobe rising edge with `sdata` low commits the word to `setup_word`. The decoded fields are `motor_cfg` = bits 2:0, `blank_ab` = bits 4:3, `blank_cd` = bits 6:5 and `reg_off` = bits 9:7.
- R3: With `awake` low, a strobe rising edge with `sdata` high commits the word to `ext_word`, and `setup_word` is left unchanged.
- R4: With `awake` high, a strobe commits the word to `step_word` whatever the `sdata` level, and `setup_word` and `ext_word` hold their values.
- R5: While `awake` is low, `step_word` is held at zero.
- R6: A strobe that follows any number of `sclk` falls other than 16 since the previous strobe writes nothing and raises `frame_err` for exactly one cycle.
- R7: A strobe rising edge within `MASK_CYC` cycles of a change on `awake` is ignored: no bank is written and `frame_err` stays low.
- R8: `mon_out` follows the code in `ext_word[3:0]`, one cycle after the code changes. Codes 0 to 9 select `mon_sigs[code]`. Codes 10, 11 and 12 give `DEV_ID` bits 0, 1 and 2. Code 13 gives `VEND_ID`.
- R9: Codes 14 and 15 in `ext_word[3:0]` drive `mon_out` to a constant 1.
- R10: While `rst` is high, all three banks read zero, `mon_out` reads 1 and `frame_err` reads 0.
- R11: The strobe level during shifting has no effect. A strobe held high across the bits and lowered just before the committing rise writes the same word as a strobe held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial shift clock; data is taken on its falling edge |
| sdata | input | 1 | Serial data; its level at the strobe edge picks the bank while asleep |
| sstrobe | input | 1 | Commit strobe; active on its rising edge |
| awake | input | 1 | Low selects configuration mode, high selects run mode |
| mon_sigs | input | N_MON | Status signals offered to the monitor pin |
| setup_word | output | WORD_W | Setup bank contents |
| ext_word | output | WORD_W | Extended bank contents |
| step_word | output | WORD_W | Stepper parameter bank contents |
| motor_cfg | output | 3 | Motor configuration select |
| blank_ab | output | 2 | Blanking select for the first bridge pair |
| blank_cd | output | 2 | Blanking select for the second bridge pair |
| reg_off | output | 3 | Regulator off bits, 1 means off |
| mon_out | output | 1 | Registered monitor output |
| frame_err | output | 1 | One-cycle pulse on a rejected strobe |

## Verification
The most likely wrong internal states are a miscounted fall counter, a mask counter that never clears, and a bank select that decodes the wrong level. Each of these appears at the ports within four system cycles of the strobe that follows: a bank word differs from the word that was shifted in, or `frame_err` pulses when it should not, or fails to pulse when it should. A wrong monitor table entry shows on `mon_out` one cycle after the extended code is written. For that reason every code from 10 to 15 is written directly, and the random mix also changes the status inputs.

// File: rtl/scp_pkg.sv
package scp_pkg;
  typedef enum logic [1:0] {
    BANK_NONE  = 2'd0,
    BANK_SETUP = 2'd1,
    BANK_EXT   = 2'd2,
    BANK_STEP  = 2'd3
  } bank_e;
endpackage

// File: rtl/scp_frontend.sv
module scp_frontend #(
  parameter int WORD_W   = 16,
  parameter int MASK_CYC = 600
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              sstrobe,
  input  logic              awake,
  output logic [WORD_W-1:0] word_o,
  output logic              dsel_o,
  output logic              awk_q_o,
  output logic              stb_rise_o,
  output logic              masked_o,
  output logic              stb_ok_o,
  output logic              stb_bad_o
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam int MW    = $clog2(MASK_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic sclk_q, sclk_d, sdat_q, stb_q, stb_d, awk_q, awk_d;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  falls;
  logic [MW-1:0]     mcnt;
  logic fall, rise, chg, masked;

  // input sampling and edge history
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0; sclk_d <= 1'b0; sdat_q <= 1'b0;
      stb_q  <= 1'b0; stb_d  <= 1'b0;
      awk_q  <= 1'b0; awk_d  <= 1'b0;
    end else begin
      sclk_q <= sclk;   sclk_d <= sclk_q;
      sdat_q <= sdata;
      stb_q  <= sstrobe; stb_d <= stb_q;
      awk_q  <= awake;  awk_d  <= awk_q;
    end
  end

  assign fall   = sclk_d & ~sclk_q;
  assign rise   = stb_q & ~stb_d;
  assign chg    = awk_q ^ awk_d;
  assign masked = chg | (mcnt != '0);

  // shift register, new bit enters at bit 0
  always_ff @(posedge clk) begin
    if (rst)       shreg <= '0;
    else if (fall) shreg <= {shreg[WORD_W-2:0], sdat_q};
  end

  // falls since the previous strobe, saturating one past a full word
  always_ff @(posedge clk) begin
    if (rst)                          falls <= '0;
    else if (rise)                    falls <= '0;
    else if (fall && falls != CNT_SAT) falls <= falls + 1'b1;
  end

  // strobe mask window after a mode change
  always_ff @(posedge clk) begin
    if (rst)             mcnt <= '0;
    else if (chg)        mcnt <= MW'(MASK_CYC);
    else if (mcnt != '0) mcnt <= mcnt - 1'b1;
  end

  assign word_o     = shreg;
  assign dsel_o     = sdat_q;
  assign awk_q_o    = awk_q;
  assign stb_rise_o = rise;
  assign masked_o   = masked;
  assign stb_ok_o   = rise & ~masked & (falls == CNT_FULL);
  assign stb_bad_o  = rise & ~masked & (falls != CNT_FULL);
endmodule

// File: rtl/scp_banks.sv
module scp_banks
  import scp_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              awk_q,
  input  logic              wr_ok,
  input  logic              wr_bad,
  input  logic              dsel,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] setup_q,
  output logic [WORD_W-1:0] ext_q,
  output logic [WORD_W-1:0] step_q,
  output logic              err_q
);
  bank_e sel;

  always_comb begin
    if (!wr_ok)     sel = BANK_NONE;
    else if (awk_q) sel = BANK_STEP;
    else if (dsel)  sel = BANK_EXT;
    else            sel = BANK_SETUP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      setup_q <= '0;
      ext_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= wr_bad;
      if (sel == BANK_SETUP) setup_q <= word;
      if (sel == BANK_EXT)   ext_q   <= word;
    end
  end

  // stepper bank is cleared for as long as the port is asleep
  always_ff @(posedge clk) begin
    if (rst || !awk_q)         step_q <= '0;
    else if (sel == BANK_STEP) step_q <= word;
  end
endmodule

// File: rtl/scp_monmux.sv
module scp_monmux #(
  parameter int         N_SIG   = 10,
  parameter logic [2:0] DEV_ID  = 3'b110,
  parameter logic       VEND_ID = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       code,
  input  logic [N_SIG-1:0] sigs,
  output logic             mon_q
);
  logic [15:0] tbl;

  for (genvar g = 0; g < 16; g++) begin : g_tbl
    if (g < N_SIG) begin : g_sig
      assign tbl[g] = sigs[g];
    end else if (g < N_SIG + 3) begin : g_dev
      assign tbl[g] = DEV_ID[g - N_SIG];
    end else if (g == N_SIG + 3) begin : g_vend
      assign tbl[g] = VEND_ID;
    end else begin : g_off
      assign tbl[g] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mon_q <= 1'b1;
    else     mon_q <= tbl[code];
  end
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
  parameter int         WORD_W   = 16,
  parameter int         MASK_CYC = 600,
  parameter int         N_MON    = 10,
  parameter logic [2:0] DEV_ID   = 3'b110,
  parameter logic       VEND_ID  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              sstrobe,
  input  logic              awake,
  input  logic [N_MON-1:0]  mon_sigs,
  output logic [WORD_W-1:0] setup_word,
  output logic [WORD_W-1:0] ext_word,
  output logic [WORD_W-1:0] step_word,
  output logic [2:0]        motor_cfg,
  output logic [1:0]        blank_ab,
  output logic [1:0]        blank_cd,
  output logic [2:0]        reg_off,
  output logic              mon_out,
  output logic              frame_err
);
  logic [WORD_W-1:0] word;
  logic dsel, awk_q, stb_rise, masked, stb_ok, stb_bad;

  scp_frontend #(.WORD_W(WORD_W), .MASK_CYC(MASK_CYC)) u_fe (
    .clk(clk), .rst(rst), .sclk(sclk), .sdata(sdata), .sstrobe(sstrobe),
    .awake(awake), .word_o(word), .dsel_o(dsel), .awk_q_o(awk_q),
    .stb_rise_o(stb_rise), .masked_o(masked), .stb_ok_o(stb_ok),
    .stb_bad_o(stb_bad)
  );

  scp_banks #(.WORD_W(WORD_W)) u_banks (
    .clk(clk), .rst(rst), .awk_q(awk_q), .wr_ok(stb_ok), .wr_bad(stb_bad),
    .dsel(dsel), .word(word), .setup_q(setup_word), .ext_q(ext_word),
    .step_q(step_word), .err_q(frame_err)
  );

  scp_monmux #(.N_SIG(N_MON), .DEV_ID(DEV_ID), .VEND_ID(VEND_ID)) u_mon (
    .clk(clk), .rst(rst), .code(ext_word[3:0]), .sigs(mon_sigs),
    .mon_q(mon_out)
  );

  assign motor_cfg = setup_word[2:0];
  assign blank_ab  = setup_word[4:3];
  assign blank_cd  = setup_word[6:5];
  assign reg_off   = setup_word[9:7];
endmodule

// File: rtl/scp_chk.sv
module scp_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              awk_q,
  input logic              stb_rise,
  input logic              masked,
  input logic              stb_bad,
  input logic              frame_err,
  input logic              mon_out,
  input logic [WORD_W-1:0] setup_word,
  input logic [WORD_W-1:0] ext_word,
  input logic [WORD_W-1:0] step_word
);
  // R5
  step_sleep_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !awk_q |=> (step_word == '0));

  // R4
  run_keeps_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    awk_q |=> ($stable(setup_word) && $stable(ext_word)));

  // R7
  masked_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (stb_rise && masked) |=> ($stable(setup_word) && $stable(ext_word) && !frame_err));

  // R6
  err_single_chk: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> !frame_err);

  // R6
  bad_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    stb_bad |=> ($stable(setup_word) && $stable(ext_word) && frame_err));

  // R9
  mon_release_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_word[3:1] == 3'b111) |=> mon_out);
endmodule

bind serial_cfg_port scp_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .awk_q(awk_q), .stb_rise(stb_rise), .masked(masked),
  .stb_bad(stb_bad), .frame_err(frame_err), .mon_out(mon_out),
  .setup_word(setup_word), .ext_word(ext_word), .step_word(step_word)
);

// File: tb/tb_serial_cfg_port.sv
`timescale 1ns/1ps
module tb_serial_cfg_port;
  localparam int         MASK = 40;
  localparam logic [2:0] DEV  = 3'b110;
  localparam logic       VEND = 1'b0;

  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b0, sdata = 1'b0, sstrobe = 1'b0, awake = 1'b0;
  logic [9:0]  mon_sigs = '0;
  logic [15:0] setup_word, ext_word, step_word;
  logic [2:0]  motor_cfg, reg_off;
  logic [1:0]  blank_ab, blank_cd;
  logic        mon_out, frame_err;

  int n_chk = 0, n_bad = 0, n_err = 0, exp_err = 0;
  logic [15:0] m_setup = '0, m_ext = '0, m_step = '0;

  serial_cfg_port #(.WORD_W(16), .MASK_CYC(MASK), .N_MON(10),
                    .DEV_ID(DEV), .VEND_ID(VEND)) dut (
    .clk(clk), .rst(rst), .sclk(sclk), .sdata(sdata), .sstrobe(sstrobe),
    .awake(awake), .mon_sigs(mon_sigs), .setup_word(setup_word),
    .ext_word(ext_word), .step_word(step_word), .motor_cfg(motor_cfg),
    .blank_ab(blank_ab), .blank_cd(blank_cd), .reg_off(reg_off),
    .mon_out(mon_out), .frame_err(frame_err)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) if (!rst && frame_err) n_err++;

  function automatic logic exp_mon(logic [15:0] e, logic [9:0] s);
    int c = int'(e[3:0]);
    if (c < 10) return s[c];
    if (c < 13) return DEV[c-10];
    if (c == 13) return VEND;
    return 1'b1;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // shift nbits (MSB of w first), then strobe with data level dl
  task automatic xfer(logic [15:0] w, int nbits, logic dl, bit late_toggle);
    if (sstrobe && ($urandom % 2 == 0)) sstrobe = 1'b0;
    for (int i = nbits - 1; i >= 0; i--) begin
      sdata = w[i % 16];
      sclk = 1'b1; cyc(2);
      sclk = 1'b0; cyc(2);
    end
    sstrobe = 1'b0;
    sdata = dl;
    if (late_toggle) awake = ~awake;
    cyc(2);
    sstrobe = 1'b1;
    cyc(4);
    if ($urandom % 2 == 0) sstrobe = 1'b0;
    if (!awake) m_step = '0;
  endtask

  task automatic check_all(string tag);
    chk({tag, " R2 setup"}, setup_word, m_setup);
    chk({tag, " R3 ext"}, ext_word, m_ext);
    chk({tag, " R4 step"}, step_word, m_step);
    chk({tag, " R2 fields"}, {6'd0, reg_off, blank_cd, blank_ab, motor_cfg}, {6'd0, m_setup[9:0]});
    chk({tag, " R8 mon"}, {15'd0, mon_out}, {15'd0, exp_mon(m_ext, mon_sigs)});
    chk({tag, " R6 errcount"}, 16'(n_err), 16'(exp_err));
  endtask

  task automatic normal_op(logic [15:0] w, logic dl);
    xfer(w, 16, dl, 1'b0);
    if (!awake) begin
      if (dl) m_ext = w; else m_setup = w;
    end else m_step = w;
  endtask

  initial begin
    void'($urandom(32'd2718));
    cyc(3);
    // R10 reset state
    chk("R10 setup", setup_word, 16'h0);
    chk("R10 ext", ext_word, 16'h0);
    chk("R10 step", step_word, 16'h0);
    chk("R10 mon", {15'd0, mon_out}, 16'h1);
    chk("R10 err", {15'd0, frame_err}, 16'h0);
    rst = 1'b0;
    cyc(MASK + 10);

    // R1 R2 directed: field positions
    normal_op(16'b0000_0010_1011_0101, 1'b0);
    check_all("dir_setup");
    // R3 + R8/R9 every ID and off code
    for (int c = 10; c < 16; c++) begin
      normal_op(16'(c) | 16'hA5A0, 1'b1);
      check_all("dir_code");
    end
    // R11 strobe held high through shifting
    sstrobe = 1'b1; cyc(2);
    n_err = 0; exp_err = 0;
    normal_op(16'h0155, 1'b0);
    check_all("R11 high_strobe");
    // R6 short and long frames
    xfer(16'h1234, 15, 1'b0, 1'b0); exp_err++;
    check_all("R6 short");
    xfer(16'h4321, 17, 1'b1, 1'b0); exp_err++;
    check_all("R6 long");
    // R4 R5 run mode
    awake = 1'b1; cyc(MASK + 10);
    normal_op(16'hBEEF, 1'b1);
    check_all("R4 run");
    // R7 strobe inside mask window
    xfer(16'h7777, 16, 1'b0, 1'b1);
    check_all("R7 masked");
    cyc(MASK + 10);
    chk("R5 step zero", step_word, 16'h0);

    // random mix
    for (int k = 0; k < 150; k++) begin
      int r = int'($urandom % 10);
      logic [15:0] w = 16'($urandom);
      mon_sigs = 10'($urandom);
      if (r == 0) begin
        awake = ~awake; cyc(MASK + 10);
        if (!awake) m_step = '0;
        check_all("rnd R5 toggle");
      end else if (r == 1) begin
        xfer(w, 16, 1'($urandom), 1'b1);
        check_all("rnd R7 masked");
        cyc(MASK + 10);
      end else if (r == 2) begin
        xfer(w, ($urandom % 2) ? 15 : 17, 1'($urandom), 1'b0);
        exp_err++;
        check_all("rnd R6 len");
      end else begin
        normal_op(w, 1'($urandom));
        check_all("rnd R1 word");
      end
    end

    // R10 mid-run reset
    @(negedge clk) rst = 1'b1;
    cyc(2);
    chk("R10 mid setup", setup_word, 16'h0);
    chk("R10 mid ext", ext_word, 16'h0);
    chk("R10 mid step", step_word, 16'h0);
    chk("R10 mid mon", {15'd0, mon_out}, 16'h1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule